// File: doc/BRIEF.md
# Deflection Routing Node Controller

This block is the electronic decision logic for a single switching node in a bufferless, multi-level cyclic routing fabric. Each node has two packet inputs, one arriving along its own level and one arriving from the next level outward. It also has two output gates. The descend gate forwards the packet to the next inner level. The stay gate keeps the packet circulating on the current level. A packet is modelled as a slot-aligned frame-valid bit plus a header of destination address bits. The payload lanes travel alongside the header and are not seen by this logic.

Every level of the fabric resolves one destination bit, starting from the most significant bit. A node at level `LEVEL` inspects header bit `ADDR_W-1-LEVEL`. If that bit equals the node's `TARGET` value and the inner neighbour is not blocking, the packet descends. Otherwise it is deflected onto the stay path and retries further along the ring. The node holds no storage for packets, so exactly one packet is routed per slot.

A packet on the same level always wins over one from the outer level. While a same-level packet is present, the node raises a block signal toward the upstream outer node. The routing decision is registered on a slot strobe that falls in the guard interval, so the gate enables are settled before the payload arrives.

Top module: `defl_node_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `desc_en`, `stay_en` and `hdr_out` are all zero.
- R2: Outputs change only on a clock edge where `slot_stb` is high. Between strobes they hold their value, whatever the inputs do.
- R3: A routed packet whose header bit `ADDR_W-1-LEVEL` equals `TARGET` while `inner_block` is low raises `desc_en` (with `stay_en` low) for the slot.
- R4: A routed packet whose header bit `ADDR_W-1-LEVEL` differs from `TARGET` raises `stay_en` (with `desc_en` low).
- R5: When `inner_block` is high at the strobe, a valid packet raises `stay_en` and never `desc_en`, even if its address bit matches.
- R6: When `same_vld` and `outer_vld` are both high, the same-level packet is routed and the outer packet has no effect on the gates or on `hdr_out`.
- R7: `block_up` follows `same_vld` within the same cycle, with no register between them.
- R8: A strobe with neither input valid leaves both gates low and `hdr_out` zero for that slot.
- R9: `desc_en` and `stay_en` are never high together.
- R10: `hdr_out` equals the header of the packet routed in the slot, whichever gate it takes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slot_stb | input | 1 | One-cycle pulse in the guard interval; latches the slot decision |
| same_vld | input | 1 | Frame-valid bit of the packet on the same level |
| same_hdr | input | ADDR_W | Destination header of the same-level packet |
| outer_vld | input | 1 | Frame-valid bit of the packet from the outer level |
| outer_hdr | input | ADDR_W | Destination header of the outer-level packet |
| inner_block | input | 1 | Inner neighbour's descend path is occupied |
| desc_en | output | 1 | Gate enable toward the next inner level |
| stay_en | output | 1 | Gate enable along the current level |
| hdr_out | output | ADDR_W | Copy of the routed packet's header |
| block_up | output | 1 | Block indication to the upstream outer node |

## Verification
The bench builds the node with a four-bit address, `LEVEL` set to 1 and `TARGET` set to 1, so the decision rests on header bit 2, a middle bit. With a middle bit, a routing error on either side of the inspected bit shows up as a wrong gate. Both match polarities and every header value are reachable from either input. A pseudo-random header stream runs against an independent model of the descend rule. Directed slots then combine inner blocking, contention between the two inputs and idle strobes, and the hold behaviour between strobes is checked.

// File: rtl/dnode_pkg.sv
`timescale 1ns/1ps
// Shared types for the deflection node controller.
package dnode_pkg;

    // Gate selection decided for one slot.
    typedef enum logic [1:0] {
        RT_IDLE = 2'd0,
        RT_DESC = 2'd1,
        RT_STAY = 2'd2
    } route_e;

endpackage

// File: rtl/dnode_arb.sv
`timescale 1ns/1ps
// dnode_arb: picks the one packet that the node routes in a slot.
// Assumes that the upstream node honours the block indication. An outer
// packet that arrives during a same-level slot is therefore discarded.
module dnode_arb #(
    parameter int ADDR_W = 4
) (
    input  logic              same_vld,
    input  logic [ADDR_W-1:0] same_hdr,
    input  logic              outer_vld,
    input  logic [ADDR_W-1:0] outer_hdr,
    output logic              pick_vld,
    output logic [ADDR_W-1:0] pick_hdr
);

    // Same-level traffic wins; otherwise take the outer packet; otherwise nothing.
    always_comb begin
        if (same_vld) begin
            pick_vld = 1'b1;
            pick_hdr = same_hdr;
        end else if (outer_vld) begin
            pick_vld = 1'b1;
            pick_hdr = outer_hdr;
        end else begin
            pick_vld = 1'b0;
            pick_hdr = '0;
        end
    end

endmodule

// File: rtl/dnode_route.sv
`timescale 1ns/1ps
// dnode_route: turns the level's address bit into a gate choice.
// Assumes that the caller has already extracted the bit that this level resolves.
module dnode_route #(
    parameter logic TARGET = 1'b1
) (
    input  logic              pick_vld,
    input  logic              addr_bit,
    input  logic              inner_block,
    output dnode_pkg::route_e route
);
    import dnode_pkg::*;

    // Descend only on a bit match with a free inner path; otherwise deflect.
    always_comb begin
        if (!pick_vld)
            route = RT_IDLE;
        else if ((addr_bit == TARGET) && !inner_block)
            route = RT_DESC;
        else
            route = RT_STAY;
    end

endmodule

// File: rtl/dnode_slot_reg.sv
`timescale 1ns/1ps
// dnode_slot_reg: holds the gate enables and the header copy for a whole slot.
// Assumes that slot_stb is a single-cycle pulse placed inside the guard time.
module dnode_slot_reg #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_stb,
    input  dnode_pkg::route_e route,
    input  logic [ADDR_W-1:0] pick_hdr,
    output logic              desc_en,
    output logic              stay_en,
    output logic [ADDR_W-1:0] hdr_out
);
    import dnode_pkg::*;

    // Latch the decision at the strobe and keep it until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_en <= 1'b0;
            stay_en <= 1'b0;
            hdr_out <= '0;
        end else if (slot_stb) begin
            desc_en <= (route == RT_DESC);
            stay_en <= (route == RT_STAY);
            hdr_out <= (route == RT_IDLE) ? '0 : pick_hdr;
        end
    end

endmodule

// File: rtl/defl_node_ctrl.sv
`timescale 1ns/1ps
// defl_node_ctrl: control for one node of a bufferless cyclic deflection fabric.
// A level-LEVEL node resolves header bit ADDR_W-1-LEVEL. It descends when that
// bit equals TARGET and the inner path is free; otherwise it deflects. It
// assumes slot-aligned inputs that are stable at the slot strobe.
module defl_node_ctrl #(
    parameter int   ADDR_W = 4,
    parameter int   LEVEL  = 1,
    parameter logic TARGET = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_stb,
    input  logic              same_vld,
    input  logic [ADDR_W-1:0] same_hdr,
    input  logic              outer_vld,
    input  logic [ADDR_W-1:0] outer_hdr,
    input  logic              inner_block,
    output logic              desc_en,
    output logic              stay_en,
    output logic [ADDR_W-1:0] hdr_out,
    output logic              block_up
);
    import dnode_pkg::*;

    localparam int BIT_IDX = ADDR_W - 1 - LEVEL;

    logic              pick_vld;
    logic [ADDR_W-1:0] pick_hdr;
    route_e            route;

    dnode_arb #(.ADDR_W(ADDR_W)) u_arb (
        .same_vld  (same_vld),
        .same_hdr  (same_hdr),
        .outer_vld (outer_vld),
        .outer_hdr (outer_hdr),
        .pick_vld  (pick_vld),
        .pick_hdr  (pick_hdr)
    );

    dnode_route #(.TARGET(TARGET)) u_route (
        .pick_vld    (pick_vld),
        .addr_bit    (pick_hdr[BIT_IDX]),
        .inner_block (inner_block),
        .route       (route)
    );

    dnode_slot_reg #(.ADDR_W(ADDR_W)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_stb (slot_stb),
        .route    (route),
        .pick_hdr (pick_hdr),
        .desc_en  (desc_en),
        .stay_en  (stay_en),
        .hdr_out  (hdr_out)
    );

    // Warn the outer neighbour at once while a same-level packet occupies the node.
    always_comb block_up = same_vld;

endmodule

// File: rtl/defl_node_ctrl_chk.sv
`timescale 1ns/1ps
// defl_node_ctrl_chk: temporal properties of the node controller, bound to the top.
module defl_node_ctrl_chk #(
    parameter int   ADDR_W = 4,
    parameter int   LEVEL  = 1,
    parameter logic TARGET = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slot_stb,
    input logic              same_vld,
    input logic [ADDR_W-1:0] same_hdr,
    input logic              outer_vld,
    input logic [ADDR_W-1:0] outer_hdr,
    input logic              inner_block,
    input logic              desc_en,
    input logic              stay_en,
    input logic [ADDR_W-1:0] hdr_out
);
    localparam int BIT_IDX = ADDR_W - 1 - LEVEL;

    p_one_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(desc_en && stay_en));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_stb |=> ($stable(desc_en) && $stable(stay_en) && $stable(hdr_out)));

    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb && !same_vld && !outer_vld) |=> (!desc_en && !stay_en && hdr_out == '0));

    p_inner_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb && inner_block && (same_vld || outer_vld)) |=> (stay_en && !desc_en));

    p_priority_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb && same_vld) |=> (hdr_out == $past(same_hdr)));

    p_descend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb && same_vld && !inner_block && same_hdr[BIT_IDX] == TARGET) |=> desc_en);

    p_mismatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb && !same_vld && outer_vld && outer_hdr[BIT_IDX] != TARGET) |=> (stay_en && hdr_out == $past(outer_hdr)));

endmodule

bind defl_node_ctrl defl_node_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .LEVEL  (LEVEL),
    .TARGET (TARGET)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_stb    (slot_stb),
    .same_vld    (same_vld),
    .same_hdr    (same_hdr),
    .outer_vld   (outer_vld),
    .outer_hdr   (outer_hdr),
    .inner_block (inner_block),
    .desc_en     (desc_en),
    .stay_en     (stay_en),
    .hdr_out     (hdr_out)
);

// File: tb/test_defl_node_ctrl.sv
`timescale 1ns/1ps
module test_defl_node_ctrl;
    localparam int   ADDR_W  = 4;
    localparam int   LEVEL   = 1;
    localparam logic TARGET  = 1'b1;
    localparam int   BIT_IDX = ADDR_W - 1 - LEVEL;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              slot_stb = 1'b0;
    logic              same_vld = 1'b0;
    logic [ADDR_W-1:0] same_hdr = '0;
    logic              outer_vld = 1'b0;
    logic [ADDR_W-1:0] outer_hdr = '0;
    logic              inner_block = 1'b0;
    logic              desc_en;
    logic              stay_en;
    logic [ADDR_W-1:0] hdr_out;
    logic              block_up;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    defl_node_ctrl #(.ADDR_W(ADDR_W), .LEVEL(LEVEL), .TARGET(TARGET)) i_defl_node_ctrl (
        .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb),
        .same_vld(same_vld), .same_hdr(same_hdr),
        .outer_vld(outer_vld), .outer_hdr(outer_hdr),
        .inner_block(inner_block),
        .desc_en(desc_en), .stay_en(stay_en), .hdr_out(hdr_out), .block_up(block_up)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one slot, strobe it, and return at the following falling edge.
    task automatic run_slot(input logic sv, input logic [ADDR_W-1:0] sh,
                            input logic ov, input logic [ADDR_W-1:0] oh,
                            input logic ib);
        @(negedge clk);
        same_vld = sv; same_hdr = sh; outer_vld = ov; outer_hdr = oh;
        inner_block = ib; slot_stb = 1'b1;
        #1 chk("R7 block_up", int'(block_up), int'(sv));
        @(posedge clk);
        @(negedge clk);
        slot_stb = 1'b0;
    endtask

    // Independent model of the expected gates and header for a slot.
    task automatic expect_slot(input string req, input logic sv, input logic [ADDR_W-1:0] sh,
                               input logic ov, input logic [ADDR_W-1:0] oh, input logic ib);
        logic v;
        logic [ADDR_W-1:0] h;
        logic d;
        v = sv | ov;
        h = sv ? sh : (ov ? oh : '0);
        d = v && (h[BIT_IDX] == TARGET) && !ib;
        chk({req, " desc_en"}, int'(desc_en), int'(d));
        chk({req, " stay_en"}, int'(stay_en), int'(v && !d));
        chk({req, " hdr_out"}, int'(hdr_out), int'(h));
        chk("R9 one gate", int'(desc_en && stay_en), 0);
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 desc_en", int'(desc_en), 0);
        chk("R1 stay_en", int'(stay_en), 0);
        chk("R1 hdr_out", int'(hdr_out), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_descend;
        run_slot(1'b1, 4'b0100, 1'b0, 4'b0000, 1'b0);
        expect_slot("R3 same match", 1'b1, 4'b0100, 1'b0, 4'b0000, 1'b0);
        run_slot(1'b0, 4'b0000, 1'b1, 4'b1111, 1'b0);
        expect_slot("R3 outer match", 1'b0, 4'b0000, 1'b1, 4'b1111, 1'b0);
    endtask

    task automatic t_mismatch;
        run_slot(1'b1, 4'b1011, 1'b0, 4'b0000, 1'b0);
        expect_slot("R4 same mismatch", 1'b1, 4'b1011, 1'b0, 4'b0000, 1'b0);
        run_slot(1'b0, 4'b0000, 1'b1, 4'b0001, 1'b0);
        expect_slot("R10 outer mismatch", 1'b0, 4'b0000, 1'b1, 4'b0001, 1'b0);
    endtask

    task automatic t_inner_block;
        run_slot(1'b1, 4'b0110, 1'b0, 4'b0000, 1'b1);
        expect_slot("R5 blocked", 1'b1, 4'b0110, 1'b0, 4'b0000, 1'b1);
        chk("R5 stay forced", int'(stay_en), 1);
    endtask

    task automatic t_priority;
        run_slot(1'b1, 4'b0010, 1'b1, 4'b1100, 1'b0);
        expect_slot("R6 contention", 1'b1, 4'b0010, 1'b1, 4'b1100, 1'b0);
        chk("R6 outer ignored", int'(hdr_out), 2);
    endtask

    task automatic t_idle;
        run_slot(1'b0, 4'b0111, 1'b0, 4'b0101, 1'b0);
        expect_slot("R8 idle", 1'b0, 4'b0000, 1'b0, 4'b0000, 1'b0);
    endtask

    task automatic t_hold;
        run_slot(1'b1, 4'b1101, 1'b0, 4'b0000, 1'b0);
        same_hdr = 4'b0000; outer_vld = 1'b1; outer_hdr = 4'b0011; inner_block = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 hold desc_en", int'(desc_en), 1);
        chk("R2 hold stay_en", int'(stay_en), 0);
        chk("R2 hold hdr_out", int'(hdr_out), 13);
    endtask

    task automatic t_random;
        logic [7:0] lfsr = 8'hA5;
        for (int i = 0; i < 200; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            run_slot(lfsr[0], lfsr[7:4], lfsr[1], lfsr[5:2], lfsr[6] & lfsr[2]);
            expect_slot("R3 R4 random", lfsr[0], lfsr[7:4], lfsr[1], lfsr[5:2], lfsr[6] & lfsr[2]);
        end
    endtask

    initial begin
        t_reset();
        t_descend();
        t_mismatch();
        t_inner_block();
        t_priority();
        t_idle();
        t_hold();
        t_random();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule